// File: doc/BRIEF.md
# Banked Host Register Window with Interrupt Control

This block sits between a byte-wide host bus and the receive/transmit machinery of a network controller. The host sees sixteen byte locations. Offset 14 always selects one of four register banks, and offset 15 always returns a fixed identification byte. The other fourteen offsets map to the registers of the bank that is currently selected. The block keeps the configuration and control registers, the interrupt status and mask, and a packet pointer. Through a data window in bank 2 the host reads and writes a packet buffer RAM that lies outside the block and is made of `PAGE_CNT` pages of 2^`PAGE_AW` bytes.

Interrupt sources outside the block raise status bits through one-cycle set pulses. A status bit stays set until the host acknowledges it. The interrupt line is high whenever a status bit is set and its mask bit is also set. The transmit-empty bit works differently: it is forced on again on every cycle in which the transmit queue is empty. The packet page the data window uses comes either from the head of the receive queue or from the current packet number. Both values arrive as inputs. The byte address within the page can step forward after each access.

The host drives `host_rd` or `host_wr` for one cycle for each byte access. A read's data appears on `host_rdata` after the clock edge that samples the strobe, and it holds there until the next read. Both strobes must be low except during an access.

Top module: `hif_reg_window`

## Requirements
- R1: A write to offset 14 sets the bank from `host_wdata[1:0]` in every bank, and a read of offset 14 returns `{6'b0, bank}`. Offset 15 reads 0x33 in every bank, and a write to offset 15 changes nothing. No write to any other offset, except the soft reset of R11, changes the bank.
- R2: After `rst_n` the bank is 0, the mask is 0x00, the status is 0x04 and the pointer is 0. Bank 1 offsets 0/1 read 0xB1/0xA0 (config), bank 1 offsets 12/13 read 0x10/0x12 (control), and bank 3 offset 12 reads 0x1F.
- R3: Bank 2 offset 12 reads the status and offset 13 reads and writes the mask. `irq` is 1 exactly when (status AND mask) is nonzero. Status bit 2 is transmit-empty, bit 3 is allocation done and bit 0 is receive done.
- R4: A one-cycle pulse on `ev_set[i]` sets status bit i on the next clock edge, and the bit stays set until it is cleared.
- R5: A write to bank 2 offset 12 clears the status bits that are set both in the written byte and in 0xD6. Bits 0 and 3 cannot be cleared this way. If a set pulse arrives in the same cycle as the acknowledge, the set wins.
- R6: On every clock edge at which `tx_empty` is 1, status bit 2 becomes 1, so an acknowledge cannot clear that bit while the queue is empty.
- R7: The data window is bank 2, offsets 8 to 11. Its page is `rx_head_page` when pointer bit 15 is 1 and `pkt_num` when bit 15 is 0. `buf_addr` = {page, byte address}.
- R8: When pointer bit 14 is 1, a data-window access uses pointer bits 10:0 as the byte address. The access then increments those 11 bits once, wrapping from 0x7FF to 0x000, and leaves bits 15:11 unchanged.
- R9: When pointer bit 14 is 0, the byte address is pointer bits 10:0 plus `host_addr[1:0]`, and the pointer does not change. A data-window write drives `buf_we` high with `buf_wdata` equal to the written byte.
- R10: Bank 2 offsets 6/7 hold the low and high bytes of the pointer, and offset 7 reads the high byte ANDed with 0xF7. Bank 3 offsets 8, 9, 10 and 11 read 0x30, 0x33, 0x91 and 0x33.
- R11: A write to bank 0 offset 5 with bit 7 set restores the R2 state (bank, mask, status, pointer, config, control, early-receive). The interrupt line is low on the next cycle.
- R12: A write to bank 1 offset 12 stores the byte with bits 1:0 forced to 0. A write to bank 3 offset 12 keeps only bits 4:0.
- R13: Read data is registered. It shows the addressed value in the cycle after the read strobe and stays unchanged through cycles without a read. A data-window read returns `buf_rdata` for the address of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Byte offset in the window |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe, has priority over read |
| ev_set | input | 8 | One-cycle set pulses for the status bits |
| tx_empty | input | 1 | Transmit queue holds no entries |
| rx_head_page | input | PG_W | Page at the head of the receive queue |
| pkt_num | input | PG_W | Current packet number page |
| buf_addr | output | PG_W+PAGE_AW | Packet buffer byte address |
| buf_we | output | 1 | Packet buffer write enable |
| buf_wdata | output | 8 | Packet buffer write byte |
| buf_rdata | input | 8 | Packet buffer read byte, combinational from buf_addr |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt request |

## Verification
A wrong status bit shows at `irq` on the cycle after the event that caused it, provided the bit is unmasked. It also shows on the next status read in bank 2, so the bench keeps a reference copy of status and mask and compares `irq` after every single access. A wrong pointer shows immediately on `buf_addr` during the next data-window strobe, and one cycle later as a wrong `host_rdata`. A pointer increment that is missing or doubled therefore shows by the second window access, and a bank register error shows on the first read that depends on the bank.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef logic [1:0] bank_t;

  localparam logic [3:0]  OFF_BANK      = 4'd14;
  localparam logic [3:0]  OFF_ID        = 4'd15;
  localparam logic [7:0]  ID_BYTE       = 8'h33;
  localparam logic [7:0]  REV_BYTE      = 8'h91;
  localparam logic [7:0]  MGMT_BYTE     = 8'h30;
  localparam logic [7:0]  PHY_STAT_HI   = 8'h40;
  localparam logic [7:0]  ACK_MASK      = 8'hD6;
  localparam logic [7:0]  ST_RESET      = 8'h04;
  localparam logic [7:0]  PTR_HI_MASK   = 8'hF7;
  localparam logic [7:0]  CTL_LO_MASK   = 8'hFC;
  localparam int unsigned TXE_BIT       = 2;
  localparam int unsigned ST_W          = 8;
  localparam logic [15:0] CFG_RESET     = 16'hA0B1;
  localparam logic [15:0] CTL_RESET     = 16'h1210;
  localparam logic [4:0]  ERX_RESET     = 5'h1F;
  localparam int unsigned PTR_RXSEL_BIT = 15;
  localparam int unsigned PTR_AUTO_BIT  = 14;
  localparam int unsigned SRST_BIT      = 7;
endpackage

// File: rtl/hif_bank_regs.sv
module hif_bank_regs
  import hif_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  off,
  input  logic [7:0]  wdata,
  output bank_t       bank_q,
  output logic [15:0] tcr_q,
  output logic [15:0] rcr_q,
  output logic [15:0] cfg_q,
  output logic [15:0] gpr_q,
  output logic [15:0] ctl_q,
  output logic [4:0]  erx_q,
  output logic        soft_rst
);
  bank_t       bank_d;
  logic [15:0] tcr_d, rcr_d, cfg_d, gpr_d, ctl_d;
  logic [4:0]  erx_d;

  assign soft_rst = wr_en && (bank_q == 2'd0) && (off == 4'd5) && wdata[SRST_BIT];

  always_comb begin
    bank_d = bank_q;
    tcr_d  = tcr_q;
    rcr_d  = rcr_q;
    cfg_d  = cfg_q;
    gpr_d  = gpr_q;
    ctl_d  = ctl_q;
    erx_d  = erx_q;
    if (off == OFF_BANK) begin
      bank_d = wdata[1:0];
    end else if (off != OFF_ID) begin
      unique case (bank_q)
        2'd0: begin
          case (off)
            4'd0: tcr_d[7:0]  = wdata;
            4'd1: tcr_d[15:8] = wdata;
            4'd4: rcr_d[7:0]  = wdata;
            4'd5: rcr_d[15:8] = wdata;
            default: ;
          endcase
        end
        2'd1: begin
          case (off)
            4'd0:  cfg_d[7:0]  = wdata;
            4'd1:  cfg_d[15:8] = wdata;
            4'd10: gpr_d[7:0]  = wdata;
            4'd11: gpr_d[15:8] = wdata;
            4'd12: ctl_d[7:0]  = wdata & CTL_LO_MASK;
            4'd13: ctl_d[15:8] = wdata;
            default: ;
          endcase
        end
        2'd3: begin
          if (off == 4'd12) erx_d = wdata[4:0];
        end
        default: ;
      endcase
    end
    if (soft_rst) begin
      bank_d = '0;
      tcr_d  = '0;
      rcr_d  = '0;
      cfg_d  = CFG_RESET;
      ctl_d  = CTL_RESET;
      erx_d  = ERX_RESET;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      tcr_q  <= '0;
      rcr_q  <= '0;
      cfg_q  <= CFG_RESET;
      gpr_q  <= '0;
      ctl_q  <= CTL_RESET;
      erx_q  <= ERX_RESET;
    end else if (wr_en) begin
      bank_q <= bank_d;
      tcr_q  <= tcr_d;
      rcr_q  <= rcr_d;
      cfg_q  <= cfg_d;
      gpr_q  <= gpr_d;
      ctl_q  <= ctl_d;
      erx_q  <= erx_d;
    end
  end
endmodule

// File: rtl/hif_irq_ctrl.sv
module hif_irq_ctrl
  import hif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            ack_we,
  input  logic [ST_W-1:0] ack_val,
  input  logic            mask_we,
  input  logic [ST_W-1:0] mask_val,
  input  logic [ST_W-1:0] ev_set,
  input  logic            tx_empty,
  output logic [ST_W-1:0] status_q,
  output logic [ST_W-1:0] mask_q,
  output logic            irq
);
  logic [ST_W-1:0] status_d;
  logic [ST_W-1:0] mask_d;
  logic            status_en;
  logic            mask_en;

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    logic ack_clr;
    logic lvl_set;
    if (ACK_MASK[i]) begin : g_clr
      assign ack_clr = ack_we & ack_val[i];
    end else begin : g_keep
      assign ack_clr = 1'b0;
    end
    if (i == TXE_BIT) begin : g_lvl
      assign lvl_set = tx_empty;
    end else begin : g_nolvl
      assign lvl_set = 1'b0;
    end
    assign status_d[i] = soft_rst ? ST_RESET[i]
                                  : ((status_q[i] & ~ack_clr) | ev_set[i] | lvl_set);
  end

  assign status_en = soft_rst | ack_we | (|ev_set) | tx_empty;
  assign mask_d    = soft_rst ? '0 : mask_val;
  assign mask_en   = soft_rst | mask_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_RESET;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/hif_buf_window.sv
module hif_buf_window
  import hif_pkg::*;
#(
  parameter  int unsigned PAGE_AW  = 11,
  parameter  int unsigned PAGE_CNT = 4,
  localparam int unsigned PG_W     = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1,
  localparam int unsigned BUF_AW   = PG_W + PAGE_AW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ptr_lo_we,
  input  logic              ptr_hi_we,
  input  logic [7:0]        wdata,
  input  logic              win_acc,
  input  logic [1:0]        lane,
  input  logic [PG_W-1:0]   rx_head_page,
  input  logic [PG_W-1:0]   pkt_page,
  output logic [15:0]       ptr_q,
  output logic [BUF_AW-1:0] buf_addr
);
  logic [15:0]        ptr_d;
  logic               ptr_en;
  logic               auto_inc;
  logic [PAGE_AW-1:0] base;
  logic [PAGE_AW-1:0] byte_addr;
  logic [PG_W-1:0]    page;

  assign auto_inc  = ptr_q[PTR_AUTO_BIT];
  assign base      = ptr_q[PAGE_AW-1:0];
  assign byte_addr = auto_inc ? base : (base + PAGE_AW'(lane));
  assign page      = ptr_q[PTR_RXSEL_BIT] ? rx_head_page : pkt_page;
  assign buf_addr  = {page, byte_addr};

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_lo_we) ptr_d[7:0]  = wdata;
    if (ptr_hi_we) ptr_d[15:8] = wdata;
    if (win_acc && auto_inc) ptr_d[PAGE_AW-1:0] = base + 1'b1;
    if (soft_rst) ptr_d = '0;
  end

  assign ptr_en = soft_rst | ptr_lo_we | ptr_hi_we | (win_acc & auto_inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/hif_reg_window.sv
module hif_reg_window
  import hif_pkg::*;
#(
  parameter  int unsigned PAGE_AW  = 11,
  parameter  int unsigned PAGE_CNT = 4,
  localparam int unsigned PG_W     = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1,
  localparam int unsigned BUF_AW   = PG_W + PAGE_AW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [7:0]        ev_set,
  input  logic              tx_empty,
  input  logic [PG_W-1:0]   rx_head_page,
  input  logic [PG_W-1:0]   pkt_num,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic [7:0]        host_rdata,
  output logic              irq
);
  bank_t       bank_q;
  logic [15:0] tcr_q, rcr_q, cfg_q, gpr_q, ctl_q, ptr_q;
  logic [4:0]  erx_q;
  logic [7:0]  status_q, mask_q;
  logic        soft_rst;
  logic        rd_eff, in_b2, win_acc, ack_we, mask_we, ptr_lo_we, ptr_hi_we;
  logic [7:0]  rd_val;

  assign rd_eff    = host_rd & ~host_wr;
  assign in_b2     = (bank_q == 2'd2);
  assign win_acc   = (rd_eff | host_wr) & in_b2 & (host_addr[3:2] == 2'b10);
  assign ack_we    = host_wr & in_b2 & (host_addr == 4'd12);
  assign mask_we   = host_wr & in_b2 & (host_addr == 4'd13);
  assign ptr_lo_we = host_wr & in_b2 & (host_addr == 4'd6);
  assign ptr_hi_we = host_wr & in_b2 & (host_addr == 4'd7);
  assign buf_we    = host_wr & win_acc;
  assign buf_wdata = host_wdata;

  hif_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr),
    .off      (host_addr),
    .wdata    (host_wdata),
    .bank_q   (bank_q),
    .tcr_q    (tcr_q),
    .rcr_q    (rcr_q),
    .cfg_q    (cfg_q),
    .gpr_q    (gpr_q),
    .ctl_q    (ctl_q),
    .erx_q    (erx_q),
    .soft_rst (soft_rst)
  );

  hif_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .ack_we   (ack_we),
    .ack_val  (host_wdata),
    .mask_we  (mask_we),
    .mask_val (host_wdata),
    .ev_set   (ev_set),
    .tx_empty (tx_empty),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  hif_buf_window #(
    .PAGE_AW  (PAGE_AW),
    .PAGE_CNT (PAGE_CNT)
  ) u_win (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .ptr_lo_we    (ptr_lo_we),
    .ptr_hi_we    (ptr_hi_we),
    .wdata        (host_wdata),
    .win_acc      (win_acc),
    .lane         (host_addr[1:0]),
    .rx_head_page (rx_head_page),
    .pkt_page     (pkt_num),
    .ptr_q        (ptr_q),
    .buf_addr     (buf_addr)
  );

  always_comb begin
    rd_val = '0;
    if (host_addr == OFF_BANK) begin
      rd_val = {6'b0, bank_q};
    end else if (host_addr == OFF_ID) begin
      rd_val = ID_BYTE;
    end else begin
      unique case (bank_q)
        2'd0: begin
          case (host_addr)
            4'd0: rd_val = tcr_q[7:0];
            4'd1: rd_val = tcr_q[15:8];
            4'd3: rd_val = PHY_STAT_HI;
            4'd4: rd_val = rcr_q[7:0];
            4'd5: rd_val = rcr_q[15:8];
            4'd9: rd_val = 8'(PAGE_CNT);
            default: rd_val = '0;
          endcase
        end
        2'd1: begin
          case (host_addr)
            4'd0:  rd_val = cfg_q[7:0];
            4'd1:  rd_val = cfg_q[15:8];
            4'd10: rd_val = gpr_q[7:0];
            4'd11: rd_val = gpr_q[15:8];
            4'd12: rd_val = ctl_q[7:0];
            4'd13: rd_val = ctl_q[15:8];
            default: rd_val = '0;
          endcase
        end
        2'd2: begin
          case (host_addr)
            4'd2:  rd_val = 8'(pkt_num);
            4'd6:  rd_val = ptr_q[7:0];
            4'd7:  rd_val = ptr_q[15:8] & PTR_HI_MASK;
            4'd8, 4'd9, 4'd10, 4'd11: rd_val = buf_rdata;
            4'd12: rd_val = status_q;
            4'd13: rd_val = mask_q;
            default: rd_val = '0;
          endcase
        end
        default: begin
          case (host_addr)
            4'd8:  rd_val = MGMT_BYTE;
            4'd9:  rd_val = ID_BYTE;
            4'd10: rd_val = REV_BYTE;
            4'd11: rd_val = ID_BYTE;
            4'd12: rd_val = {3'b0, erx_q};
            default: rd_val = '0;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (rd_eff) begin
      host_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/hif_reg_window_chk.sv
module hif_reg_window_chk
  import hif_pkg::*;
#(
  parameter  int unsigned PAGE_AW  = 11,
  parameter  int unsigned PAGE_CNT = 4,
  localparam int unsigned PG_W     = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1,
  localparam int unsigned BUF_AW   = PG_W + PAGE_AW
)(
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        host_addr,
  input logic              host_wr,
  input logic [7:0]        ev_set,
  input logic              tx_empty,
  input logic [PG_W-1:0]   rx_head_page,
  input logic [BUF_AW-1:0] buf_addr,
  input logic              irq,
  input logic [1:0]        bank_q,
  input logic [7:0]        status_q,
  input logic [15:0]       ptr_q,
  input logic              soft_rst,
  input logic              win_acc,
  input logic              ack_we
);
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != OFF_BANK && !soft_rst) |=> $stable(bank_q)); // R1

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && |ev_set) |=> ((status_q & $past(ev_set)) == $past(ev_set))); // R4

  AST_ACK_SPARES_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !ev_set[3] && !ev_set[0]) |=>
      (status_q[3] == $past(status_q[3]) && status_q[0] == $past(status_q[0]))); // R5

  AST_TXE_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> status_q[TXE_BIT]); // R6

  AST_RX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && ptr_q[PTR_RXSEL_BIT]) |-> (buf_addr[BUF_AW-1:PAGE_AW] == rx_head_page)); // R7

  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && ptr_q[PTR_AUTO_BIT]) |=>
      (ptr_q[PAGE_AW-1:0] == PAGE_AW'($past(ptr_q[PAGE_AW-1:0]) + 1'b1))); // R8

  AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !ptr_q[PTR_AUTO_BIT]) |=> $stable(ptr_q)); // R9

  AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && bank_q == 2'd0)); // R11
endmodule

bind hif_reg_window hif_reg_window_chk #(
  .PAGE_AW  (PAGE_AW),
  .PAGE_CNT (PAGE_CNT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_addr    (host_addr),
  .host_wr      (host_wr),
  .ev_set       (ev_set),
  .tx_empty     (tx_empty),
  .rx_head_page (rx_head_page),
  .buf_addr     (buf_addr),
  .irq          (irq),
  .bank_q       (bank_q),
  .status_q     (status_q),
  .ptr_q        (ptr_q),
  .soft_rst     (soft_rst),
  .win_acc      (win_acc),
  .ack_we       (ack_we)
);

// File: tb/hif_reg_window_bench.sv
module hif_reg_window_bench;
  localparam int unsigned PAGE_AW = 11;
  localparam int unsigned PAGE_CNT = 4;
  localparam int unsigned PG_W = 2;
  localparam int unsigned BUF_AW = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        host_addr = '0;
  logic [7:0]        host_wdata = '0;
  logic              host_rd = 1'b0;
  logic              host_wr = 1'b0;
  logic [7:0]        ev_set = '0;
  logic              tx_empty = 1'b0;
  logic [PG_W-1:0]   rx_head_page = 2'd1;
  logic [PG_W-1:0]   pkt_num = 2'd3;
  logic [BUF_AW-1:0] buf_addr;
  logic              buf_we;
  logic [7:0]        buf_wdata;
  logic [7:0]        buf_rdata;
  logic [7:0]        host_rdata;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [1:0]        m_bank = 2'd0;
  logic [7:0]        m_status = 8'h04;
  logic [7:0]        m_mask = 8'h00;
  logic [15:0]       m_ptr = 16'h0000;
  logic              m_txe = 1'b0;
  logic [BUF_AW-1:0] exp_a;
  logic [BUF_AW-1:0] cap_addr;
  logic              cap_we;
  logic [7:0]        cap_wd;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram_f(input logic [BUF_AW-1:0] a);
    return a[7:0] ^ {3'b0, a[12:8]};
  endfunction

  assign buf_rdata = ram_f(buf_addr);

  hif_reg_window #(.PAGE_AW(PAGE_AW), .PAGE_CNT(PAGE_CNT)) u_hif_reg_window (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .ev_set(ev_set), .tx_empty(tx_empty),
    .rx_head_page(rx_head_page), .pkt_num(pkt_num), .buf_addr(buf_addr),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  function automatic logic [BUF_AW-1:0] exp_addr(input logic [3:0] off);
    logic [PG_W-1:0]    pg;
    logic [PAGE_AW-1:0] b;
    pg = m_ptr[15] ? rx_head_page : pkt_num;
    b  = m_ptr[14] ? m_ptr[10:0] : (m_ptr[10:0] + 11'(off[1:0]));
    return {pg, b};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input logic [3:0] off, input logic [7:0] d);
    bit win;
    win = (m_bank == 2'd2) && (off[3:2] == 2'b10);
    if (w && off == 4'd14) begin
      m_bank = d[1:0];
    end else if (w && off != 4'd15) begin
      if (m_bank == 2'd0 && off == 4'd5 && d[7]) begin
        m_bank = 2'd0; m_status = 8'h04; m_mask = 8'h00; m_ptr = 16'h0000;
      end else if (m_bank == 2'd2) begin
        case (off)
          4'd6:  m_ptr[7:0]  = d;
          4'd7:  m_ptr[15:8] = d;
          4'd12: m_status = m_status & ~(d & 8'hD6);
          4'd13: m_mask = d;
          default: ;
        endcase
      end
    end
    if (win && m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
    if (m_txe) m_status = m_status | 8'h04;
  endtask

  task automatic access(input bit w, input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    host_addr = off; host_wdata = d; host_wr = w; host_rd = ~w;
    exp_a = exp_addr(off);
    #1;
    cap_addr = buf_addr; cap_we = buf_we; cap_wd = buf_wdata;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    model_step(w, off, d);
    check("R3 irq", 16'(irq), 16'(|(m_status & m_mask)));
  endtask

  task automatic rd_chk(input logic [3:0] off, input logic [7:0] e, input string tag);
    access(1'b0, off, 8'h00);
    check(tag, 16'(host_rdata), 16'(e));
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); ev_set = v;
    @(negedge clk); ev_set = 8'h00;
    m_status = m_status | v;
    if (m_txe) m_status = m_status | 8'h04;
    check("R4 irq", 16'(irq), 16'(|(m_status & m_mask)));
  endtask

  task automatic set_txe(input logic v);
    @(negedge clk); tx_empty = v; m_txe = v;
    @(negedge clk);
    if (v) m_status = m_status | 8'h04;
    check("R6 irq", 16'(irq), 16'(|(m_status & m_mask)));
  endtask

  task automatic win_read(input logic [3:0] off, input string tag);
    access(1'b0, off, 8'h00);
    check(tag, 16'(cap_addr), 16'(exp_a));
    check("R13 window data", 16'(host_rdata), 16'(ram_f(exp_a)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_chk(4'd14, 8'h00, "R2 bank after reset");
    check("R2 irq after reset", 16'(irq), 16'd0);
    rd_chk(4'd15, 8'h33, "R1 id byte");
    access(1'b1, 4'd15, 8'h5A);
    rd_chk(4'd14, 8'h00, "R1 write to 15 ignored");
    rd_chk(4'd15, 8'h33, "R1 id byte after write");

    access(1'b1, 4'd14, 8'h01);
    rd_chk(4'd14, 8'h01, "R1 bank readback");
    rd_chk(4'd0, 8'hB1, "R2 config low");
    rd_chk(4'd1, 8'hA0, "R2 config high");
    rd_chk(4'd12, 8'h10, "R2 control low");
    rd_chk(4'd13, 8'h12, "R2 control high");
    access(1'b1, 4'd12, 8'hFF);
    rd_chk(4'd12, 8'hFC, "R12 control low mask");

    access(1'b1, 4'd14, 8'h03);
    rd_chk(4'd12, 8'h1F, "R2 early receive reset");
    access(1'b1, 4'd12, 8'hEE);
    rd_chk(4'd12, 8'h0E, "R12 early receive mask");
    rd_chk(4'd10, 8'h91, "R10 revision");
    rd_chk(4'd11, 8'h33, "R10 bank3 offset 11");
    rd_chk(4'd9, 8'h33, "R10 bank3 offset 9");
    rd_chk(4'd8, 8'h30, "R10 bank3 offset 8");
    access(1'b1, 4'd12, 8'h01);
    check("R13 read data holds", 16'(host_rdata), 16'h0030);

    access(1'b1, 4'd14, 8'h02);
    rd_chk(4'd12, 8'h04, "R2 status reset");
    rd_chk(4'd13, 8'h00, "R2 mask reset");
    pulse(8'hFF);
    rd_chk(4'd12, 8'hFF, "R4 sticky set");
    access(1'b1, 4'd12, 8'hFF);
    rd_chk(4'd12, 8'h29, "R5 ack spares bits 0 and 3");
    access(1'b1, 4'd13, 8'h08);
    check("R3 irq from alloc bit", 16'(irq), 16'd1);
    access(1'b1, 4'd13, 8'h02);
    check("R3 irq masked", 16'(irq), 16'd0);

    set_txe(1'b1);
    access(1'b1, 4'd12, 8'h04);
    rd_chk(4'd12, 8'h2D, "R6 tx empty reasserted");
    set_txe(1'b0);
    access(1'b1, 4'd12, 8'h04);
    rd_chk(4'd12, 8'h29, "R6 tx empty cleared when queue busy");

    access(1'b1, 4'd6, 8'hFE);
    access(1'b1, 4'd7, 8'hCF);
    rd_chk(4'd7, 8'hC7, "R10 pointer high mask");
    win_read(4'd8, "R7 rx head page");
    check("R8 first address", 16'(cap_addr), 16'h0FFE);
    win_read(4'd9, "R8 step");
    check("R8 second address", 16'(cap_addr), 16'h0FFF);
    win_read(4'd11, "R8 wrap");
    check("R8 wrapped address", 16'(cap_addr), 16'h0800);
    rd_chk(4'd6, 8'h01, "R8 pointer low after wrap");
    rd_chk(4'd7, 8'hC0, "R8 pointer high kept");

    access(1'b1, 4'd7, 8'h01);
    access(1'b1, 4'd6, 8'h00);
    for (int k = 0; k < 4; k++) begin
      access(1'b1, 4'(8 + k), 8'(8'hA0 + k));
      check("R9 write enable", 16'(cap_we), 16'd1);
      check("R9 write data", 16'(cap_wd), 16'(8'hA0 + k));
      check("R9 lane address", 16'(cap_addr), 16'(13'h1900 + k));
    end
    rd_chk(4'd6, 8'h00, "R9 pointer unchanged");
    pkt_num = 2'd2;
    win_read(4'd10, "R7 packet number page");
    check("R7 page from pkt_num", 16'(cap_addr), 16'h1102);

    access(1'b1, 4'd13, 8'hFF);
    check("R3 irq all unmasked", 16'(irq), 16'd1);
    access(1'b1, 4'd14, 8'h00);
    access(1'b1, 4'd5, 8'h80);
    check("R11 irq low after soft reset", 16'(irq), 16'd0);
    rd_chk(4'd14, 8'h00, "R11 bank after soft reset");
    access(1'b1, 4'd14, 8'h01);
    rd_chk(4'd0, 8'hB1, "R11 config restored");
    access(1'b1, 4'd14, 8'h02);
    rd_chk(4'd12, 8'h04, "R11 status restored");
    rd_chk(4'd13, 8'h00, "R11 mask restored");
    rd_chk(4'd6, 8'h00, "R11 pointer restored");

    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 7))
        0: access(1'b1, 4'd12, 8'($urandom));
        1: access(1'b1, 4'd13, 8'($urandom));
        2: pulse(8'($urandom));
        3: set_txe(1'($urandom));
        4: begin
          e = m_status;
          rd_chk(4'd12, e, "R5 random status");
        end
        5: access(1'b1, 4'($urandom_range(6, 7)), 8'($urandom));
        6: win_read(4'($urandom_range(8, 11)), "R7 random window address");
        default: begin
          e = m_mask;
          rd_chk(4'd13, e, "R3 random mask");
        end
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule